// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a 32-bit event timer. Its counter is clocked by a tick chain: the tick comes either from the system clock, which may first be divided by 16, or from rising edges on an asynchronous external clock pin. Either way the tick then passes through an 8-bit prescaler. In compare mode the counter is matched against a reference value, and on a match it either restarts from zero or keeps running. In capture mode the counter runs freely and its value is latched on a chosen edge of a synchronized capture pin.

Every capture or compare event sets a sticky event flag. The flag can drive an interrupt line, and the event can also raise a DMA request that stays high until the DMA engine acknowledges it. Software reaches the timer through a small register port. Writes take effect on the clock edge where the write strobe is high. Reads are combinational.

Top module: `cctimer32`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads zero, and `irq` and `dma_req` are low.
- R2: Control register (address 0) fields are: bit0 enable, bit1 external source, bit2 divide-by-16, bit3 capture mode (0 = compare), bits5:4 edge select, bit6 restart on match, bit7 interrupt enable, bit8 DMA enable. The prescaler value P is at address 1, bits 7:0. With the system clock selected, the counter advances floor(floor(k/D)/(P+1)) times in the k clock edges after the edge that writes enable. D is 16 when bit2 is set and 1 otherwise.
- R3: With the external source selected, the counter advances once per P+1 rising edges of `ext_clk`, after a two-flop synchronizer. The system clock does not advance it, and the divide-by-16 bit has no effect.
- R4: While enable is 0 the counter holds its value. A write to address 4 loads the counter. The counter wraps modulo 2^32.
- R5: In compare mode, a counter tick that finds the counter equal to the reference (address 2) is an event. With restart set, that tick loads zero, so the counter cycles through 0..REF.
- R6: In compare mode with restart clear, a match still raises an event but the counter keeps incrementing.
- R7: In capture mode the edge select codes are 00 none, 01 rising, 10 falling and 11 both. On a selected edge of `cap_in`, address 3 latches the counter value as it stands two system clock edges after the first edge that samples the new pin level, and an event is raised. Address 3 is read-only.
- R8: The event flag is bit 0 of address 5. Writing 1 there clears it, and writing 0 has no effect. An event in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when the event flag is set and interrupt enable is 1.
- R10: With DMA enable set, an event raises `dma_req`, which stays high until a cycle with `dma_ack` high clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ext_clk | input | 1 | Asynchronous external count clock |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
The assertions assume that `ext_clk` and `cap_in` hold each level for at least two system clock cycles, because a narrower pulse may slip through the synchronizers unseen. They also assume `bus_addr` is stable while `bus_wr` is high. The stimulus changes both pins and all bus signals only on falling clock edges, holds each pin level for four or more cycles, and uses only the six decoded addresses. Expected counts come from the tick-chain formula in R2, swept over every prescaler value from 0 to 7 and both divider settings.

// File: rtl/cctimer32_pkg.sv
package cctimer32_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_PRESC = 3'd1,
        REG_REF   = 3'd2,
        REG_CAPT  = 3'd3,
        REG_COUNT = 3'd4,
        REG_STAT  = 3'd5
    } reg_addr_e;

    // Packed MSB first: dma_en lands on bit 8, enable on bit 0.
    typedef struct packed {
        logic      dma_en;
        logic      irq_en;
        logic      restart;
        edge_sel_e edge_sel;
        logic      capture;
        logic      div_sel;
        logic      ext_src;
        logic      enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic edge_seen(edge_sel_e sel, logic now, logic prev);
        logic hit;
        unique case (sel)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = now & ~prev;
            EDGE_FALL: hit = ~now & prev;
            EDGE_ANY:  hit = now ^ prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cctimer32_sync.sv
module cctimer32_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cctimer32_tick.sv
module cctimer32_tick #(
    parameter int PRE_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             ext_src,
    input  logic             div_sel,
    input  logic [PRE_W-1:0] presc,
    input  logic             ext_lvl,
    output logic             cnt_tick
);
    logic             ext_prev;
    logic [DIV_W-1:0] div_cnt;
    logic [PRE_W-1:0] pre_cnt;
    logic             sys_tick;
    logic             ext_rise;
    logic             base_tick;
    logic             pre_done;

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= ext_lvl;
    end

    always_comb begin
        sys_tick  = div_sel ? (div_cnt == '1) : 1'b1;
        ext_rise  = ext_lvl & ~ext_prev;
        base_tick = enable & (ext_src ? ext_rise : sys_tick);
        pre_done  = (pre_cnt >= presc);
        cnt_tick  = base_tick & pre_done;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pre_cnt <= '0;
        end else if (base_tick) begin
            if (pre_done) pre_cnt <= '0;
            else          pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cctimer32_core.sv
module cctimer32_core
    import cctimer32_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cap_lvl,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             cap_hit,
    output logic             evt
);
    logic cap_prev;
    logic cmp_hit;

    always_ff @(posedge clk) begin
        if (rst) cap_prev <= 1'b0;
        else     cap_prev <= cap_lvl;
    end

    always_comb begin
        cap_hit = ctrl.enable & ctrl.capture &
                  edge_seen(ctrl.edge_sel, cap_lvl, cap_prev);
        cmp_hit = cnt_tick & ~ctrl.capture & (count == ref_val);
        evt     = cap_hit | cmp_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= cnt_wdata;
        end else if (cnt_tick) begin
            if (cmp_hit && ctrl.restart) count <= '0;
            else                         count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          capture <= '0;
        else if (cap_hit) capture <= count;
    end
endmodule

// File: rtl/cctimer32_regs.sv
module cctimer32_regs
    import cctimer32_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  capture,
    input  logic              evt,
    input  logic              dma_ack,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  presc,
    output logic [CNT_W-1:0]  ref_val,
    output logic              cnt_wr,
    output logic              flag,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq,
    output logic              dma_req
);
    reg_addr_e sel;
    logic      clr_hit;

    always_comb begin
        sel     = reg_addr_e'(addr);
        cnt_wr  = wr && (sel == REG_COUNT);
        clr_hit = wr && (sel == REG_STAT) && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            presc   <= '0;
            ref_val <= '0;
        end else if (wr) begin
            case (sel)
                REG_CTRL:  ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
                REG_PRESC: presc   <= wdata[PRE_W-1:0];
                REG_REF:   ref_val <= wdata;
                default:   ;
            endcase
        end
    end

    // Event set has priority over software clear.
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (evt)     flag <= 1'b1;
        else if (clr_hit) flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                      dma_req <= 1'b0;
        else if (evt && ctrl.dma_en)  dma_req <= 1'b1;
        else if (dma_ack)             dma_req <= 1'b0;
    end

    assign irq = flag & ctrl.irq_en;

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL:  rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
            REG_PRESC: rdata = {{(CNT_W-PRE_W){1'b0}}, presc};
            REG_REF:   rdata = ref_val;
            REG_CAPT:  rdata = capture;
            REG_COUNT: rdata = count;
            REG_STAT:  rdata = {{(CNT_W-1){1'b0}}, flag};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/cctimer32.sv
module cctimer32
    import cctimer32_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 8,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    input  logic              cap_in,
    output logic              irq,
    output logic              dma_req,
    input  logic              dma_ack
);
    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] capt_q;
    logic             cnt_wr;
    logic             cnt_tick;
    logic             cap_hit;
    logic             evt;
    logic             stat_flag;
    logic             ext_lvl;
    logic             cap_lvl;

    cctimer32_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst(rst), .d(ext_clk), .q(ext_lvl)
    );

    cctimer32_sync #(.STAGES(SYNC_STAGES)) u_sync_cap (
        .clk(clk), .rst(rst), .d(cap_in), .q(cap_lvl)
    );

    cctimer32_tick #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl_q.enable),
        .ext_src  (ctrl_q.ext_src),
        .div_sel  (ctrl_q.div_sel),
        .presc    (presc_q),
        .ext_lvl  (ext_lvl),
        .cnt_tick (cnt_tick)
    );

    cctimer32_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .cnt_tick  (cnt_tick),
        .ref_val   (ref_q),
        .cap_lvl   (cap_lvl),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata),
        .count     (count_q),
        .capture   (capt_q),
        .cap_hit   (cap_hit),
        .evt       (evt)
    );

    cctimer32_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .count   (count_q),
        .capture (capt_q),
        .evt     (evt),
        .dma_ack (dma_ack),
        .ctrl    (ctrl_q),
        .presc   (presc_q),
        .ref_val (ref_q),
        .cnt_wr  (cnt_wr),
        .flag    (stat_flag),
        .rdata   (bus_rdata),
        .irq     (irq),
        .dma_req (dma_req)
    );
endmodule

// File: rtl/cctimer32_chk.sv
module cctimer32_chk
    import cctimer32_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             dma_req,
    input logic             dma_ack,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ref_val,
    input logic [CNT_W-1:0] capture,
    input logic             cnt_tick,
    input logic             cnt_wr,
    input logic             cap_hit,
    input logic             evt,
    input logic             stat_flag
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && !dma_req));

    // R2
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |-> !cnt_tick);

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !cnt_wr) |=> $stable(count));

    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !ctrl.capture && ctrl.restart && count == ref_val && !cnt_wr)
        |=> (count == '0));

    // R7
    capture_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_hit |=> $stable(capture));

    // R8
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> stat_flag);

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_flag && ctrl.irq_en));

    // R10
    dma_rise_from_event_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(evt));

    // R10
    dma_ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_ack && !evt) |=> !dma_req);
endmodule

bind cctimer32 cctimer32_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .ctrl      (ctrl_q),
    .count     (count_q),
    .ref_val   (ref_q),
    .capture   (capt_q),
    .cnt_tick  (cnt_tick),
    .cnt_wr    (cnt_wr),
    .cap_hit   (cap_hit),
    .evt       (evt),
    .stat_flag (stat_flag)
);

// File: tb/tb_cctimer32.sv
module tb_cctimer32;
    localparam int A_CTRL = 0, A_PRESC = 1, A_REF = 2, A_CAPT = 3, A_COUNT = 4, A_STAT = 5;
    localparam logic [31:0] C_EN = 32'h1, C_EXT = 32'h2, C_DIV = 32'h4, C_CAP = 32'h8,
                            C_RST = 32'h40, C_IRQ = 32'h80, C_DMA = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq;
    logic        dma_req;
    logic        dma_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cctimer32 dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .cap_in(cap_in), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = a[2:0];
        #1;
        d = bus_rdata;
    endtask

    task automatic fresh(input logic [31:0] presc, input logic [31:0] refv);
        wr(A_CTRL, 32'h0);
        wr(A_COUNT, 32'h0);
        wr(A_STAT, 32'h1);
        wr(A_PRESC, presc);
        wr(A_REF, refv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        logic [31:0] exp_cap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 dma_req", {31'b0, dma_req}, 32'h0);

        // R2 system clock chain: sweep divider and prescaler
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 8; p++) begin
                fresh(p, 32'hFFFF_FFFF);
                wr(A_CTRL, C_EN | (d != 0 ? C_DIV : 32'h0));
                repeat (300) @(negedge clk);
                rd(A_COUNT, v);
                chk("R2 sys count", v, (300 / (d != 0 ? 16 : 1)) / (p + 1));
            end
        end

        // R3 external clock, divide bit set but ignored
        for (int p = 0; p < 4; p++) begin
            fresh(p, 32'hFFFF_FFFF);
            wr(A_CTRL, C_EN | C_EXT | C_DIV);
            for (int n = 0; n < 9; n++) begin
                repeat (4) @(negedge clk); ext_clk = 1'b1;
                repeat (4) @(negedge clk); ext_clk = 1'b0;
            end
            repeat (8) @(negedge clk);
            rd(A_COUNT, v);
            chk("R3 ext count", v, 9 / (p + 1));
        end

        // R4 hold while disabled, load, wrap
        fresh(0, 32'hFFFF_FFFF);
        wr(A_COUNT, 32'hFFFF_FFFE);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v);
        chk("R4 hold", v, 32'hFFFF_FFFE);
        wr(A_CTRL, C_EN | C_CAP);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v);
        chk("R4 wrap", v, 32'h1);

        // R5 compare with restart, R9 interrupt
        fresh(0, 5);
        wr(A_CTRL, C_EN | C_RST | C_IRQ);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); chk("R5 before match", v, 5);
        rd(A_STAT, v);  chk("R8 flag clear", v, 0);
        chk("R9 irq low", {31'b0, irq}, 0);
        @(negedge clk);
        rd(A_COUNT, v); chk("R5 restart", v, 0);
        rd(A_STAT, v);  chk("R8 flag set", v, 1);
        chk("R9 irq high", {31'b0, irq}, 1);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); chk("R5 cycle", v, 3);

        // R8 write-0 no effect, write-1 clears
        wr(A_CTRL, C_IRQ);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R8 write0 ignored", v, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R8 w1c", v, 0);
        chk("R9 irq after clear", {31'b0, irq}, 0);

        // R8 event wins over clear in the same cycle (match at edge 12)
        fresh(0, 5);
        wr(A_CTRL, C_EN | C_RST);
        repeat (10) @(negedge clk);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R8 set wins", v, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R8 later clear", v, 0);

        // R9 interrupt disabled
        fresh(0, 5);
        wr(A_CTRL, C_EN | C_RST);
        repeat (8) @(negedge clk);
        rd(A_STAT, v); chk("R9 flag set", v, 1);
        chk("R9 irq masked", {31'b0, irq}, 0);

        // R6 free-running compare
        fresh(0, 5);
        wr(A_CTRL, C_EN | C_IRQ);
        repeat (6) @(negedge clk);
        rd(A_COUNT, v); chk("R6 no restart", v, 6);
        rd(A_STAT, v);  chk("R6 event", v, 1);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R6 keeps running", v, 10);

        // R7 capture edge select sweep
        for (int s = 0; s < 4; s++) begin
            fresh(0, 32'hFFFF_FFFF);
            rd(A_CAPT, prev);
            wr(A_CTRL, C_EN | C_CAP | (32'(s) << 4));
            repeat (10) @(negedge clk); cap_in = 1'b1;
            repeat (20) @(negedge clk); cap_in = 1'b0;
            repeat (10) @(negedge clk);
            case (s)
                0:       exp_cap = prev;
                1:       exp_cap = 12;
                default: exp_cap = 32;
            endcase
            rd(A_CAPT, v); chk("R7 capture", v, exp_cap);
            rd(A_STAT, v); chk("R7 flag", v, (s == 0) ? 0 : 1);
            wr(A_CAPT, 32'hDEAD_BEEF);
            rd(A_CAPT, v); chk("R7 read-only", v, exp_cap);
        end

        // R10 DMA request and acknowledge
        fresh(0, 3);
        wr(A_CTRL, C_EN | C_RST | C_DMA);
        repeat (3) @(negedge clk);
        chk("R10 no req yet", {31'b0, dma_req}, 0);
        @(negedge clk);
        chk("R10 req", {31'b0, dma_req}, 1);
        chk("R9 irq off with dma", {31'b0, irq}, 0);
        wr(A_CTRL, C_DMA);
        repeat (3) @(negedge clk);
        chk("R10 held", {31'b0, dma_req}, 1);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk("R10 ack clears", {31'b0, dma_req}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule